// File: doc/BRIEF.md
# UART Receive Queue with Idle-Character Ageing

This block sits between a UART deserializer and the bus-side register logic. It stores up to 32 received characters, or break events, and presents the oldest one as a 16-bit tagged word. A read strobe removes that word from the queue. The deserializer sees an accept signal and offers one character per cycle. The block does not cover bit sampling or baud generation.

Software sets a trigger level. Receive-ready goes high when a push leaves the queue at or above that level. It drops when a read leaves the queue below it. The queue keeps sticky status flags:
- overrun, for characters offered while the queue was full,
- break detect,
- ageing timeout.

The ageing timeout is raised when characters have waited below the trigger level for eight character times with no queue activity. Each flag is cleared by pulsing its own clear input. The character time is a parameter given in clock cycles.

Top module: `rxq_ageing_fifo`

## Requirements
- R1: After reset the queue is empty, `level` is 0, `rx_empty` is 1, `data_ready`, `rx_ready` and all three status flags are 0, and `rd_word` is 0.
- R2: Characters leave in arrival order. While the queue is non-empty, `rd_word` shows the oldest entry: bit 15 = 1 (character ready), bits 7:0 = data, bits 10:8 = 0. A `rd_pop` removes that entry. While the queue is empty, `rd_word` reads 0 and `rd_pop` changes nothing.
- R3: The queue holds 32 entries. `in_accept` is low while it is full. A character offered while full (with the receiver enabled) is dropped, and `ovr_flag` is set.
- R4: The push that takes the count from 31 to 32 stores its entry with bit 14 (error) and bit 13 (overrun) set.
- R5: `rx_ready` is set when a push leaves the count >= `trig_level`. It is cleared when a valid pop leaves the count < `trig_level`. Otherwise it holds its value.
- R6: Any accepted push sets `data_ready` and clears `rx_empty`. A pop that empties the queue clears `data_ready` and sets `rx_empty`.
- R7: An offered break (`in_break`) stores an entry with bits 14 (error), 12 (framing) and 11 (break) set and data 0. It also sets `brk_flag`.
- R8: While `rx_en` is low, offered characters are ignored.
- R9: While the queue is non-empty and `rx_ready` is clear, `age_flag` is set 8*CHAR_CYCLES clock cycles after the last push or pop. Each push or pop restarts that count.
- R10: The ageing count does not run while the queue is empty or `rx_ready` is set.
- R11: A one-cycle pulse on `clr_ovr`, `clr_brk` or `clr_age` clears the matching flag.
- R12: A push and a pop in the same cycle both take effect. The count is unchanged, and `rx_ready` then follows the rule of R5 applied to that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| trig_level | input | 6 | Receive-ready trigger level |
| in_valid | input | 1 | Deserializer offers a character or break |
| in_data | input | 8 | Offered character |
| in_break | input | 1 | Offered item is a break event |
| rd_pop | input | 1 | Remove the oldest entry |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_brk | input | 1 | Clear break flag |
| clr_age | input | 1 | Clear ageing-timeout flag |
| in_accept | output | 1 | Receiver enabled and queue not full |
| rd_word | output | 16 | Tagged oldest entry, or 0 when empty |
| level | output | 6 | Number of stored entries |
| rx_ready | output | 1 | Trigger level reached |
| data_ready | output | 1 | At least one entry present |
| rx_empty | output | 1 | Queue empty |
| ovr_flag | output | 1 | Sticky overrun |
| brk_flag | output | 1 | Sticky break detect |
| age_flag | output | 1 | Sticky ageing timeout |

## Verification
The assertions assume that the clear pulses, `rd_pop` and `in_valid` are synchronous to `clk`. They also assume that `trig_level` is held steady while the queue is in use, because the ready flag is only re-evaluated on a push or a pop. The stimulus drives every input on the falling edge and changes `trig_level` only between sweep passes, when the queue is empty. It applies a reset before the ageing section, so that a ready flag left set by a zero trigger level does not carry over.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int WORD_W  = 16;
    localparam int DATA_W  = 8;

    // Field positions of the word seen by the bus reader
    localparam int POS_RDY = 15;
    localparam int POS_ERR = 14;
    localparam int POS_OVR = 13;
    localparam int POS_FRM = 12;
    localparam int POS_BRK = 11;

    typedef struct packed {
        logic              err;
        logic              ovr;
        logic              frm;
        logic              brk;
        logic [DATA_W-1:0] data;
    } entry_t;

    function automatic logic [WORD_W-1:0] to_word(entry_t e);
        logic [WORD_W-1:0] w;
        w             = '0;
        w[POS_RDY]    = 1'b1;
        w[POS_ERR]    = e.err;
        w[POS_OVR]    = e.ovr;
        w[POS_FRM]    = e.frm;
        w[POS_BRK]    = e.brk;
        w[DATA_W-1:0] = e.data;
        return w;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  entry_t wr_entry,
    input  logic   rd_en,
    output entry_t head
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
    } ptr_t;

    ptr_t   st_d, st_q;
    entry_t mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        if (rd_en) st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wp] <= wr_entry;
    end

    assign head = mem[st_q.rp];

endmodule

// File: rtl/rxq_ager.sv
module rxq_ager #(
    parameter int AGE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = $clog2(AGE_CYCLES);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(AGE_CYCLES - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } age_t;

    age_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (kick) begin
            st_d.armed = run;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            if (st_q.cnt == TOP) begin
                expire     = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: an expiry cannot follow a cycle in which the timer was restarted
    a_r9_no_expire_after_kick: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !expire);

endmodule

// File: rtl/rxq_ageing_fifo.sv
module rxq_ageing_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int CHAR_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic [5:0]  trig_level,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_break,
    input  logic        rd_pop,
    input  logic        clr_ovr,
    input  logic        clr_brk,
    input  logic        clr_age,
    output logic        in_accept,
    output logic [15:0] rd_word,
    output logic [5:0]  level,
    output logic        rx_ready,
    output logic        data_ready,
    output logic        rx_empty,
    output logic        ovr_flag,
    output logic        brk_flag,
    output logic        age_flag
);

    localparam int LVL_W      = $clog2(DEPTH) + 1;
    localparam int AGE_CYCLES = 8 * CHAR_CYCLES;
    localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LAST_CNT = LVL_W'(DEPTH - 1);

    typedef struct packed {
        logic [LVL_W-1:0] count;
        logic             ready;
        logic             dready;
        logic             empty;
        logic             ovr;
        logic             brk;
        logic             age;
    } ctl_t;

    ctl_t   st_d, st_q;
    entry_t new_entry, head;
    logic   offer, full, is_empty, do_push, do_pop, fills_last;
    logic   kick, run, expire;

    always_comb begin
        st_d       = st_q;
        full       = (st_q.count == FULL_CNT);
        is_empty   = (st_q.count == '0);
        offer      = in_valid && rx_en;
        do_push    = offer && !full;
        do_pop     = rd_pop && !is_empty;
        fills_last = do_push && !do_pop && (st_q.count == LAST_CNT);

        new_entry.err  = in_break || fills_last;
        new_entry.ovr  = fills_last;
        new_entry.frm  = in_break;
        new_entry.brk  = in_break;
        new_entry.data = in_break ? '0 : in_data;

        st_d.count = st_q.count + LVL_W'(do_push) - LVL_W'(do_pop);

        if (do_pop && (st_d.count < trig_level))  st_d.ready = 1'b0;
        if (do_push && (st_d.count >= trig_level)) st_d.ready = 1'b1;

        if (do_pop && (st_d.count == '0)) begin
            st_d.dready = 1'b0;
            st_d.empty  = 1'b1;
        end
        if (do_push) begin
            st_d.dready = 1'b1;
            st_d.empty  = 1'b0;
        end

        kick = do_push || do_pop;
        run  = (st_d.count != '0) && !st_d.ready;

        if (clr_ovr)           st_d.ovr = 1'b0;
        if (offer && full)     st_d.ovr = 1'b1;
        if (clr_brk)           st_d.brk = 1'b0;
        if (offer && in_break) st_d.brk = 1'b1;
        if (clr_age)           st_d.age = 1'b0;
        if (expire)            st_d.age = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_push),
        .wr_entry (new_entry),
        .rd_en    (do_pop),
        .head     (head)
    );

    rxq_ager #(.AGE_CYCLES(AGE_CYCLES)) u_ager (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (kick),
        .run    (run),
        .expire (expire)
    );

    assign in_accept  = rx_en && !full;
    assign rd_word    = is_empty ? '0 : to_word(head);
    assign level      = 6'(st_q.count);
    assign rx_ready   = st_q.ready;
    assign data_ready = st_q.dready;
    assign rx_empty   = st_q.empty;
    assign ovr_flag   = st_q.ovr;
    assign brk_flag   = st_q.brk;
    assign age_flag   = st_q.age;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);

    a_r3_full_push_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (offer && full) |=> ovr_flag);

    a_r4_last_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
        fills_last |=> (st_q.count == FULL_CNT));

    a_r6_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty == (st_q.count == '0));

    a_r6_ready_opposes_empty: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready != rx_empty);

    a_r8_disabled_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_pop) |=> $stable(st_q.count));

    a_r10_age_only_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(age_flag) |-> (st_q.count != '0) && !rx_ready);

endmodule

// File: tb/rxq_ageing_fifo_tb.sv
module rxq_ageing_fifo_tb;

    localparam int AGE = 32; // 8 character times of 4 cycles

    logic        clk = 1'b0;
    logic        rst_n, rx_en, in_valid, in_break, rd_pop;
    logic        clr_ovr, clr_brk, clr_age, in_accept;
    logic [5:0]  trig_level, level;
    logic [7:0]  in_data;
    logic [15:0] rd_word;
    logic        rx_ready, data_ready, rx_empty, ovr_flag, brk_flag, age_flag;

    always #5 clk = ~clk;

    rxq_ageing_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .trig_level(trig_level),
        .in_valid(in_valid), .in_data(in_data), .in_break(in_break),
        .rd_pop(rd_pop), .clr_ovr(clr_ovr), .clr_brk(clr_brk), .clr_age(clr_age),
        .in_accept(in_accept), .rd_word(rd_word), .level(level),
        .rx_ready(rx_ready), .data_ready(data_ready), .rx_empty(rx_empty),
        .ovr_flag(ovr_flag), .brk_flag(brk_flag), .age_flag(age_flag)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [15:0] mq[$];
    int  mcnt;
    bit  mready, movr, mbrk, mage;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(string req);
        chk({req, " level"}, 32'(level), 32'(mcnt));
        chk({req, " rx_ready"}, 32'(rx_ready), 32'(mready));
        chk({req, " data_ready"}, 32'(data_ready), 32'(mcnt != 0));
        chk({req, " rx_empty"}, 32'(rx_empty), 32'(mcnt == 0));
        chk({req, " in_accept"}, 32'(in_accept), 32'(rx_en && mcnt != 32));
        chk({req, " flags"}, {29'd0, ovr_flag, brk_flag, age_flag}, {29'd0, movr, mbrk, mage});
        chk({req, " rd_word"}, 32'(rd_word), (mcnt == 0) ? 32'd0 : 32'(mq[0]));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_en = 1'b1; in_valid = 0; in_break = 0; rd_pop = 0;
        clr_ovr = 0; clr_brk = 0; clr_age = 0; in_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mq.delete(); mcnt = 0; mready = 0; movr = 0; mbrk = 0; mage = 0;
        @(negedge clk);
    endtask

    task automatic push(logic [7:0] d, bit brk);
        logic [15:0] w;
        in_valid = 1'b1; in_data = d; in_break = brk;
        cyc();
        in_valid = 1'b0; in_break = 1'b0;
        if (rx_en) begin
            if (brk) mbrk = 1;
            if (mcnt == 32) movr = 1;
            else begin
                w = brk ? 16'hD800 : (16'h8000 | 16'(d));
                if (mcnt == 31) w |= 16'h6000;
                mq.push_back(w);
                mcnt++;
                if (mcnt >= int'(trig_level)) mready = 1;
            end
        end
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        cyc();
        rd_pop = 1'b0;
        if (mcnt > 0) begin
            void'(mq.pop_front());
            mcnt--;
            if (mcnt < int'(trig_level)) mready = 0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) cyc();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        trig_level = 6'd1;
        do_reset();
        check_all("R1 reset");

        // R2 R3 R4 R5 R6: fill past full and drain for several trigger levels
        foreach (trig_level_set[k]) begin end
        for (int t = 0; t < 6; t++) begin
            int tl;
            tl = (t == 0) ? 1 : (t == 1) ? 5 : (t == 2) ? 16 : (t == 3) ? 31 : (t == 4) ? 32 : 0;
            trig_level = 6'(tl);
            for (int i = 0; i < 33; i++) begin
                push(8'((tl * 7 + i * 13) & 8'hFF), 1'b0);
                check_all("R3 R4 R5 fill");
            end
            chk("R4 last slot tag", 32'(mq[31] & 16'h6000), 32'h6000);
            chk("R3 overrun flag", 32'(ovr_flag), 32'd1);
            for (int i = 0; i < 33; i++) begin
                pop();
                check_all("R2 R5 R6 drain");
            end
            chk("R2 empty read", 32'(rd_word), 32'd0);
            clr_ovr = 1'b1; cyc(); clr_ovr = 1'b0; movr = 0;
            check_all("R11 clear overrun");
        end

        // R9 R10 ageing
        trig_level = 6'd4;
        do_reset();
        push(8'h11, 0); push(8'h22, 0);
        idle(AGE - 1);
        check_all("R9 age not yet");
        idle(1); mage = 1;
        check_all("R9 age expired");
        clr_age = 1'b1; cyc(); clr_age = 1'b0; mage = 0;
        check_all("R11 clear age");
        pop();
        idle(AGE / 2);
        push(8'h33, 0);
        idle(AGE - 1);
        check_all("R9 restart on push");
        idle(1); mage = 1;
        check_all("R9 expired after restart");
        clr_age = 1'b1; cyc(); clr_age = 1'b0; mage = 0;
        push(8'h44, 0); push(8'h55, 0);
        check_all("R5 ready at trigger");
        idle(AGE + 4);
        check_all("R10 no ageing when ready");
        repeat (4) pop();
        idle(AGE + 4);
        check_all("R10 no ageing when empty");

        // R7 break entry
        push(8'hAB, 1'b1);
        check_all("R7 break entry");
        chk("R7 break word", 32'(rd_word), 32'hD800);
        clr_brk = 1'b1; cyc(); clr_brk = 1'b0; mbrk = 0;
        check_all("R11 clear break");
        pop();

        // R8 receiver disabled
        rx_en = 1'b0;
        push(8'h5A, 1'b0);
        check_all("R8 disabled ignores push");
        rx_en = 1'b1;

        // R12 simultaneous push and pop
        push(8'hA1, 0);
        in_valid = 1'b1; in_data = 8'hB2; rd_pop = 1'b1;
        chk("R12 head before edge", 32'(rd_word), 32'h80A1);
        cyc();
        in_valid = 1'b0; rd_pop = 1'b0;
        void'(mq.pop_front());
        mq.push_back(16'h80B2);
        mready = (mcnt >= 4);
        check_all("R12 push and pop");

        finished = 1;
        summary();
    end

    int trig_level_set[1];

endmodule